// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters into an asynchronous serial bit stream on a single output line. A character is handed over on a valid/ready port and lands in a one-entry holding register. When the shifter is free, the character moves into the shifter, which drives a low start bit, the data bits least significant first, an optional parity bit and a high stop period. While one character is being shifted, the next one can already wait in the holding register.

Bit timing comes from a programmable divisor. The divisor makes a tick at sixteen times the baud rate. A bit lasts 16 ticks and a half stop bit lasts 8 ticks. The word length, parity kind and stop length can be set, and are captured when each frame starts. When the transmitter is switched on, the line is held high for one full frame before the first character goes out. Two status flags report the state: one for an empty holding register and one for a finished transmission. An interrupt line follows the completion flag when that interrupt is enabled.

Back-pressure on the character port: a beat is taken on a clock edge where `wr_valid` and `wr_ready` are both high. A source that honours back-pressure holds `wr_valid` until it sees `wr_ready`. A beat offered while `wr_ready` is low counts as a rejected write. It is dropped, and it sets the sticky overrun flag.

Top module: `ser_tx`

## Requirements
- R1: After reset `txd` is 1, `txe` and `wr_ready` are 1, `tc` is 1, `ovr` is 0, and `irq` is 0 while `tc_ie` is 0.
- R2: A frame starts with one bit at 0 and then sends the data bits least significant first. A data or start bit lasts exactly 16 × D clocks. D is `baud_div`, and a `baud_div` of 0 acts as 1.
- R3: With `word9` = 0 a frame carries `wr_data[7:0]`, 8 bits, and `wr_data[8]` has no effect. With `word9` = 1 it carries all 9 bits.
- R4: `par_sel` selects the parity: 0 none, 1 even (parity bit is the XOR of the data bits), 2 odd (its inverse), 3 always 0, 4 always 1, and any other value means none. When present, the parity bit is one bit long and follows the last data bit.
- R5: `stop_sel` selects the stop length at line level 1: 1 gives 8 ticks, 2 gives 24 ticks, and 0 or 3 gives 16 ticks. `tc` rises exactly 16 × D × (1 + data bits + parity bits) + stop ticks × D clocks after the falling start edge, if no further character waits.
- R6: After `tx_en` goes from 0 to 1, the line stays at 1 for at least one full frame length before the first start bit.
- R7: The holding register takes a new character while the previous one is shifting. `txe` goes back to 1 within two clocks after a character is taken, and back-to-back characters are sent in order.
- R8: A taken character clears `tc`. `tc` is 0 while a character waits or is being sent. `tc` is set at the end of a stop period when nothing waits. `irq` equals `tc` AND `tc_ie`.
- R9: A beat offered while `wr_ready` is 0 is dropped and does not show up on the line. It sets `ovr`, which then stays 1 until reset.
- R10: While `tx_en` is 0, no new frame starts and `txd` stays at 1. A character already being sent when `tx_en` falls is completed in full, and a character written while disabled waits in the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| word9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_sel | input | 3 | Parity kind (see R4) |
| stop_sel | input | 2 | Stop length (see R5) |
| baud_div | input | DIV_W | Clocks per oversample tick (0 acts as 1) |
| tc_ie | input | 1 | Completion interrupt enable |
| wr_valid | input | 1 | Character offered |
| wr_data | input | 9 | Character value |
| wr_ready | output | 1 | Holding register can take a character |
| txe | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |
| ovr | output | 1 | Sticky overrun flag |
| irq | output | 1 | Completion interrupt |
| txd | output | 1 | Serial line |

## Verification
The bench measures the exact distance from the start edge to the rise of `tc`. This finds a stop period that is off by half a bit, and a divider that makes one tick too many per bit. It also checks the case where a divisor of 0 would stall. It sends 9-bit and 8-bit characters with the top bit set, so that parity computed over the wrong width shows up as a wrong parity bit. It offers a third character while one shifts and one waits. A design that let that write through would corrupt the second frame or leave `ovr` clear. The bench also turns the enable on with a character already waiting and turns it off in the middle of a frame. A missing idle frame, a truncated frame or a start while disabled shows up as a line level sampled at the wrong time.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } stx_state_e;

  // Frame settings captured at the start of each frame
  typedef struct packed {
    logic       word9;
    logic [2:0] par;
    logic [1:0] stop;
  } stx_cfg_t;

  function automatic logic stx_has_par(input logic [2:0] m);
    return (m == 3'd1) || (m == 3'd2) || (m == 3'd3) || (m == 3'd4);
  endfunction

  function automatic logic stx_par_bit(input logic [8:0] d, input logic w9,
                                       input logic [2:0] m);
    logic x;
    x = ^(w9 ? d : {1'b0, d[7:0]});
    case (m)
      3'd1:    return x;
      3'd2:    return ~x;
      3'd4:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/stx_baud.sv
module stx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  // A zero divisor behaves as one so the tick never stalls
  assign lim  = (div == '0) ? DIV_W'(1) : div;
  assign tick = run && (cnt == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/stx_shift.sv
module stx_shift
  import stx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int TW  = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     go_gap,
  input  logic     go_data,
  input  logic [8:0] data,
  input  stx_cfg_t cfg_in,
  output logic     idle,
  output logic     done,
  output logic     txd
);
  localparam int HALF_T = OSR / 2;
  localparam int LONG_T = OSR + OSR / 2;

  stx_state_e     state;
  stx_cfg_t       cfg_q;
  logic [8:0]     sh;
  logic [3:0]     bidx;
  logic           pbit;
  logic [TW-1:0]  tcnt;

  logic [TW-1:0]  stop_t;
  logic [TW-1:0]  frame_t;
  logic [TW-1:0]  plen;
  logic           hp_q;
  logic [3:0]     last_idx;
  logic           last;

  assign hp_q     = stx_has_par(cfg_q.par);
  assign last_idx = cfg_q.word9 ? 4'd8 : 4'd7;

  always_comb begin
    case (cfg_q.stop)
      2'd1:    stop_t = TW'(HALF_T);
      2'd2:    stop_t = TW'(LONG_T);
      default: stop_t = TW'(OSR);
    endcase
    frame_t = TW'(OSR * 9) + (cfg_q.word9 ? TW'(OSR) : '0)
            + (hp_q ? TW'(OSR) : '0) + stop_t;
    case (state)
      ST_GAP:  plen = frame_t;
      ST_STOP: plen = stop_t;
      default: plen = TW'(OSR);
    endcase
  end

  assign last = tick && (tcnt == plen - 1'b1);
  assign done = last && ((state == ST_STOP) || (state == ST_GAP));
  assign idle = (state == ST_IDLE);

  always_comb begin
    case (state)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = sh[0];
      ST_PAR:   txd = pbit;
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cfg_q <= '0;
      sh    <= '0;
      bidx  <= '0;
      pbit  <= 1'b0;
      tcnt  <= '0;
    end else if (state == ST_IDLE) begin
      tcnt <= '0;
      if (go_gap) begin
        cfg_q <= cfg_in;
        state <= ST_GAP;
      end else if (go_data) begin
        cfg_q <= cfg_in;
        sh    <= cfg_in.word9 ? data : {1'b0, data[7:0]};
        pbit  <= stx_par_bit(data, cfg_in.word9, cfg_in.par);
        bidx  <= '0;
        state <= ST_START;
      end
    end else if (tick) begin
      if (last) begin
        tcnt <= '0;
        case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            sh <= {1'b0, sh[8:1]};
            if (bidx == last_idx) state <= hp_q ? ST_PAR : ST_STOP;
            else                  bidx  <= bidx + 1'b1;
          end
          ST_PAR:  state <= ST_STOP;
          default: state <= ST_IDLE;
        endcase
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ser_tx.sv
module ser_tx
  import stx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             word9,
  input  logic [2:0]       par_sel,
  input  logic [1:0]       stop_sel,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             tc_ie,
  input  logic             wr_valid,
  input  logic [8:0]       wr_data,
  output logic             wr_ready,
  output logic             txe,
  output logic             tc,
  output logic             ovr,
  output logic             irq,
  output logic             txd
);
  // Longest frame: start + 9 data + parity + 1.5 stop, plus margin
  localparam int TW = $clog2(OSR * 13 + 1);

  logic       en_q, gap_pend;
  logic [8:0] tdr;
  logic       tdr_full, tc_q, ovr_q;
  logic       accept, go_gap, go_data;
  logic       eng_idle, eng_done, tick;
  stx_cfg_t   cfg;

  assign cfg     = '{word9: word9, par: par_sel, stop: stop_sel};
  assign accept  = wr_valid && !tdr_full;
  assign go_gap  = eng_idle && gap_pend;
  assign go_data = eng_idle && !gap_pend && en_q && tdr_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      gap_pend <= 1'b0;
      tdr      <= '0;
      tdr_full <= 1'b0;
      tc_q     <= 1'b1;
      ovr_q    <= 1'b0;
    end else begin
      en_q <= tx_en;
      if (tx_en && !en_q) gap_pend <= 1'b1;
      else if (go_gap)    gap_pend <= 1'b0;
      if (accept) begin
        tdr      <= wr_data;
        tdr_full <= 1'b1;
      end else if (go_data) begin
        tdr_full <= 1'b0;
      end
      if (accept)                     tc_q <= 1'b0;
      else if (eng_done && !tdr_full) tc_q <= 1'b1;
      if (wr_valid && tdr_full) ovr_q <= 1'b1;
    end
  end

  stx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (!eng_idle),
    .div  (baud_div),
    .tick (tick)
  );

  stx_shift #(.OSR(OSR), .TW(TW)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .go_gap (go_gap),
    .go_data(go_data),
    .data   (tdr),
    .cfg_in (cfg),
    .idle   (eng_idle),
    .done   (eng_done),
    .txd    (txd)
  );

  assign wr_ready = !tdr_full;
  assign txe      = !tdr_full;
  assign tc       = tc_q;
  assign ovr      = ovr_q;
  assign irq      = tc_q && tc_ie;
endmodule

// File: rtl/stx_chk.sv
module stx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic txe,
  input logic tc,
  input logic ovr,
  input logic txd
);
  // R7: a taken character fills the holding register; R8: and clears completion
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!txe && !tc));

  // R8: completion never reported while a character waits
  p_full_blocks_tc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !txe |-> !tc);

  // R9: overrun flag is sticky
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovr) |-> ovr);

  // R5: completion is raised only once the line is back at stop level
  p_tc_rise_line_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc) |-> txd);

  // R10: nothing pending and complete means the line idles high
  p_idle_line_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && txe) |-> txd);
endmodule

bind ser_tx stx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_valid(wr_valid),
  .wr_ready(wr_ready),
  .txe     (txe),
  .tc      (tc),
  .ovr     (ovr),
  .txd     (txd)
);

// File: tb/tb_ser_tx.sv
module tb_ser_tx;
  logic        clk = 1'b0;
  logic        rst_n, tx_en, word9, tc_ie, wr_valid;
  logic [2:0]  par_sel;
  logic [1:0]  stop_sel;
  logic [15:0] baud_div;
  logic [8:0]  wr_data;
  logic        wr_ready, txe, tc, ovr, irq, txd;

  int cyc = 0;
  int errs = 0;
  int checks = 0;
  int last_t0 = 0;
  bit fin = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ser_tx dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .word9(word9), .par_sel(par_sel),
    .stop_sel(stop_sel), .baud_div(baud_div), .tc_ie(tc_ie), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .txe(txe), .tc(tc), .ovr(ovr),
    .irq(irq), .txd(txd)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_range(input string req, input string what, input int act,
                             input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  function automatic int nbits();
    return word9 ? 9 : 8;
  endfunction
  function automatic int pbits();
    return (par_sel >= 3'd1 && par_sel <= 3'd4) ? 1 : 0;
  endfunction
  function automatic int stop_ticks();
    return (stop_sel == 2'd1) ? 8 : (stop_sel == 2'd2) ? 24 : 16;
  endfunction
  function automatic int divv();
    return (baud_div == 0) ? 1 : int'(baud_div);
  endfunction
  function automatic int frame_ticks();
    return 16 * (1 + nbits() + pbits()) + stop_ticks();
  endfunction
  function automatic int exp_par(input logic [8:0] d);
    int ones = 0;
    for (int i = 0; i < nbits(); i++) if (d[i]) ones++;
    case (par_sel)
      3'd1: return ones % 2;
      3'd2: return 1 - (ones % 2);
      3'd4: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic push(input logic [8:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Capture one frame at bit centres, then check tc at the exact end
  task automatic capture(input logic [8:0] d, input int exp_tc, input string req);
    int t0, nb, hp, d1, tot;
    nb = nbits(); hp = pbits(); d1 = divv(); tot = frame_ticks();
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
    last_t0 = t0;
    for (int k = 0; k <= nb + hp; k++) begin
      int e;
      while (cyc < t0 + (16 * k + 8) * d1) @(negedge clk);
      if (k == 0)       e = 0;
      else if (k <= nb) e = int'(d[k-1]);
      else              e = exp_par(d);
      check(req, $sformatf("bit %0d of 0x%0h", k, d), int'(txd), e);
    end
    while (cyc < t0 + (16 * (1 + nb + hp) + stop_ticks() / 2) * d1) @(negedge clk);
    check("R5", "stop level", int'(txd), 1);
    while (cyc < t0 + tot * d1 - 1) @(negedge clk);
    check("R5", "tc before stop end", int'(tc), 0);
    @(negedge clk);
    check("R5", "tc at stop end", int'(tc), exp_tc);
  endtask

  task automatic t_reset();
    check("R1", "txd", int'(txd), 1);
    check("R1", "txe", int'(txe), 1);
    check("R1", "wr_ready", int'(wr_ready), 1);
    check("R1", "tc", int'(tc), 1);
    check("R1", "ovr", int'(ovr), 0);
    check("R1", "irq", int'(irq), 0);
    tc_ie = 1'b1; #1;
    check("R8", "irq follows tc", int'(irq), 1);
  endtask

  task automatic t_idle_frame();
    int lows = 0;
    int ce;
    word9 = 0; par_sel = 0; stop_sel = 0; baud_div = 2;
    push(9'h03C);
    repeat (100) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    check("R10", "low samples while disabled", lows, 0);
    check("R10", "char held while disabled", int'(txe), 0);
    tx_en = 1'b1;
    ce = cyc;
    capture(9'h03C, 1, "R6");
    check_range("R6", "enable to start", last_t0 - ce,
                frame_ticks() * divv(), frame_ticks() * divv() + 4);
  endtask

  task automatic t_basic();
    word9 = 0; par_sel = 0; stop_sel = 0; baud_div = 4;
    push(9'h0A5);
    capture(9'h0A5, 1, "R2");
    check("R8", "irq at completion", int'(irq), 1);
    tc_ie = 1'b0; #1;
    check("R8", "irq masked", int'(irq), 0);
    tc_ie = 1'b1;
  endtask

  task automatic t_div_zero();
    word9 = 0; par_sel = 0; stop_sel = 2'd1; baud_div = 0;
    push(9'h05A);
    capture(9'h05A, 1, "R2");
  endtask

  task automatic t_nine_bit();
    word9 = 1; par_sel = 3'd1; stop_sel = 2'd2; baud_div = 2;
    push(9'h1C3);
    capture(9'h1C3, 1, "R3");
    word9 = 0; par_sel = 3'd2; stop_sel = 2'd0;
    push(9'h1F0);
    capture(9'h0F0, 1, "R3");
  endtask

  task automatic t_parity();
    word9 = 0; baud_div = 2; stop_sel = 2'd3;
    par_sel = 3'd2; push(9'h0B7); capture(9'h0B7, 1, "R4");
    par_sel = 3'd3; push(9'h0FF); capture(9'h0FF, 1, "R4");
    par_sel = 3'd4; push(9'h000); capture(9'h000, 1, "R4");
    par_sel = 3'd6; push(9'h081); capture(9'h081, 1, "R4");
  endtask

  task automatic t_buffer_overrun();
    word9 = 0; par_sel = 3'd1; stop_sel = 2'd0; baud_div = 3;
    push(9'h031);
    fork
      capture(9'h031, 0, "R7");
      begin
        @(negedge clk);
        check("R7", "txe back while shifting", int'(txe), 1);
        check("R7", "line in start bit", int'(txd), 0);
        push(9'h0C2);
        @(negedge clk);
        check("R9", "ready low when full", int'(wr_ready), 0);
        wr_valid = 1'b1; wr_data = 9'h1EE;
        @(negedge clk);
        wr_valid = 1'b0;
        check("R9", "ovr after rejected write", int'(ovr), 1);
        check("R8", "tc low with waiting char", int'(tc), 0);
      end
    join
    capture(9'h0C2, 1, "R9");
    check("R9", "ovr sticky", int'(ovr), 1);
    check("R9", "nothing left pending", int'(txe), 1);
  endtask

  task automatic t_disable();
    int lows = 0;
    word9 = 0; par_sel = 0; stop_sel = 0; baud_div = 2;
    push(9'h081);
    fork
      capture(9'h081, 1, "R10");
      begin
        repeat (40) @(negedge clk);
        tx_en = 1'b0;
      end
    join
    push(9'h07E);
    repeat (400) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    check("R10", "no start while disabled", lows, 0);
    check("R10", "char still waiting", int'(txe), 0);
    tx_en = 1'b1;
    capture(9'h07E, 1, "R6");
  endtask

  initial begin
    rst_n = 0; tx_en = 0; word9 = 0; par_sel = 0; stop_sel = 0;
    baud_div = 2; tc_ie = 0; wr_valid = 0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle_frame();
    t_basic();
    t_div_zero();
    t_nine_bit();
    t_parity();
    t_buffer_overrun();
    t_disable();
    fin = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++;
      errs++;
      $display("FAIL all watchdog: actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule